// File: doc/BRIEF.md
# Host Packet-Buffer Port with DMA Handshake

This block is the host-facing access port to a network controller's packet memory. There are two byte-wide circular buffers, one for each direction. Host writes go into the transmit buffer, and the MAC side drains that buffer through a valid/ready stream. The MAC side fills the receive buffer through a second valid/ready stream, and the host reads it back. Each buffer moves its own read and write pointers after every transfer. The host therefore never manages addresses, and transmit writes may be interleaved freely with receive reads.

The port appears in the host register window at offset 08h, and only while the bank field of the control register is binary 10. When the DMA acknowledge is high, the port is selected no matter what the address or bank is. In byte-bus mode each access moves one byte. In word-bus mode each access moves two bytes, with the byte that comes first in the stream on bits [7:0].

A DMA request/acknowledge handshake serves either direction. It runs in single-cycle or burst style, and an end-of-process input stops it. The buffer streams follow the usual valid/ready rules. A byte is transferred on a clock edge where valid and ready are both high. `tx_m_valid` and `tx_m_data` stay put while `tx_m_ready` is low. `rx_s_ready` is low whenever the receive buffer is full.

Top module: `pbp_host_port`

## Requirements
- R1: A host access takes effect only when `host_sel` is high and one of two conditions holds. Either `dma_ack` is high, or `win_bank` equals 2'b10 and `host_addr` is 4'h8 (or 4'h9 in byte mode). Any other access changes no buffer and no output.
- R2: In byte mode (`word_mode`=0), a write stores `host_wdata[7:0]` as one transmit byte. A read returns one receive byte on `host_rdata[7:0]`, with `host_rdata[15:8]` set to zero.
- R3: In word mode, a write stores two bytes: `host_wdata[7:0]` first, then `host_wdata[15:8]`. A read returns the older receive byte on [7:0] and the next byte on [15:8].
- R4: In word mode, an access with `host_byte`=1 is ignored, and `err_width` is set on the next cycle.
- R5: A write that finds fewer free transmit bytes than it carries is dropped whole, and `err_overrun` is set. All error flags stay set until reset.
- R6: A read that finds fewer stored receive bytes than it needs consumes nothing, returns zero, and sets `err_underrun`.
- R7: `host_rdata` is registered. It updates on the clock edge that takes a read and otherwise holds its value. The MAC-side streams obey valid/ready: stalled transmit data holds steady, and `rx_s_ready` is low while the receive buffer holds DEPTH bytes.
- R8: The two directions keep independent pointers. Interleaved transmit writes and receive reads each keep their own byte order.
- R9: In single-cycle mode (`dma_burst`=0), `dma_req` is low in the cycle after any acknowledged cycle. It returns once the acknowledge drops and the buffer is ready.
- R10: In burst mode, `dma_req` stays high for as long as DMA is running and the selected buffer can take or give one more access. It drops when the buffer is full (transmit) or empty (receive).
- R11: `dma_start` begins DMA. If `dma_eop` is high in a cycle where `dma_ack` is high, that cycle's transfer completes, DMA stops, and `dma_req` stays low until the next `dma_start`. `dma_eop` without `dma_ack` has no effect.
- R12: `dma_dir`=1 makes the DMA request follow transmit space (host to buffer). `dma_dir`=0 makes it follow stored receive data (buffer to host).
- R13: A synchronous active-high `rst` empties both buffers, stops DMA, and clears `host_rdata` and every error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1 = 16-bit host bus, 0 = 8-bit |
| win_bank | input | 2 | Bank field of the host control register |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_byte | input | 1 | Access is byte-sized (illegal in word mode) |
| host_addr | input | 4 | Register offset in the window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| dma_start | input | 1 | Pulse that starts DMA |
| dma_burst | input | 1 | 1 = burst, 0 = single-cycle |
| dma_dir | input | 1 | 1 = transmit, 0 = receive |
| dma_ack | input | 1 | DMA acknowledge; selects the port |
| dma_eop | input | 1 | End of process, acts only with `dma_ack` |
| dma_req | output | 1 | DMA request |
| tx_m_valid | output | 1 | Transmit stream byte available |
| tx_m_ready | input | 1 | MAC side accepts transmit byte |
| tx_m_data | output | 8 | Transmit stream byte |
| rx_s_valid | input | 1 | Receive stream byte offered |
| rx_s_ready | output | 1 | Receive buffer has room |
| rx_s_data | input | 8 | Receive stream byte |
| err_width | output | 1 | Sticky: byte access in word mode |
| err_overrun | output | 1 | Sticky: transmit write dropped |
| err_underrun | output | 1 | Sticky: receive read had no data |

## Verification
The hardest case to reach from the ports is the end of a burst. `dma_req` must fall on exactly the edge where the transmit buffer fills, and an end-of-process must then hold it low even after space frees up again. The stimulus keeps `dma_ack` and a write strobe high on every cycle of an empty-buffer burst. It checks the request before each edge, then drains the buffer to show the request returning. Finally it raises end-of-process, first alone and then together with an acknowledge. A word read against a one-byte receive buffer is also staged deliberately, to show that a failed read consumes nothing.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam logic [3:0] PORT_OFFSET = 4'h8;
  localparam logic [3:0] PORT_OFFSET_HI = 4'h9;
  localparam logic [1:0] PORT_BANK = 2'b10;
  typedef enum logic {DMA_IDLE, DMA_RUN} dma_state_e;
endpackage

// File: rtl/pbp_byte_fifo.sv
module pbp_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int IN_BYTES = 1,
  parameter int OUT_BYTES = 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             push_n,
  input  logic [IN_BYTES*8-1:0]  wdata,
  input  logic [1:0]             pop_n,
  output logic [OUT_BYTES*8-1:0] head,
  output logic [CW-1:0]          count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_BYTES; i++)
      if (int'(push_n) > i) mem[wp_q + AW'(i)] <= wdata[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + AW'(push_n);
      rp_q  <= rp_q + AW'(pop_n);
      cnt_q <= cnt_q + CW'(push_n) - CW'(pop_n);
    end
  end

  for (genvar g = 0; g < OUT_BYTES; g++) begin : g_head
    assign head[g*8 +: 8] = mem[rp_q + AW'(g)];
  end

  assign count = cnt_q;
endmodule

// File: rtl/pbp_access_dec.sv
module pbp_access_dec
  import pbp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        word_mode,
  input  logic [1:0]  win_bank,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic        host_byte,
  input  logic [3:0]  host_addr,
  input  logic        dma_ack,
  input  logic        tx_room,
  input  logic        rx_avail,
  input  logic [15:0] rx_head,
  output logic [1:0]  tx_push_n,
  output logic [1:0]  rx_pop_n,
  output logic [15:0] host_rdata,
  output logic        err_width,
  output logic        err_overrun,
  output logic        err_underrun
);
  logic [1:0] need;
  logic addr_hit, hit, bad_width, wr_go, rd_go;

  assign need      = word_mode ? 2'd2 : 2'd1;
  assign addr_hit  = (host_addr == PORT_OFFSET) ||
                     (!word_mode && host_addr == PORT_OFFSET_HI);
  assign hit       = host_sel && (dma_ack || (addr_hit && win_bank == PORT_BANK));
  assign bad_width = hit && word_mode && host_byte;
  assign wr_go     = hit && !bad_width && host_wr;
  assign rd_go     = hit && !bad_width && !host_wr;
  assign tx_push_n = (wr_go && tx_room) ? need : 2'd0;
  assign rx_pop_n  = (rd_go && rx_avail) ? need : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata   <= '0;
      err_width    <= 1'b0;
      err_overrun  <= 1'b0;
      err_underrun <= 1'b0;
    end else begin
      if (bad_width) err_width <= 1'b1;
      if (wr_go && !tx_room) err_overrun <= 1'b1;
      if (rd_go && !rx_avail) err_underrun <= 1'b1;
      if (rd_go) begin
        if (!rx_avail)      host_rdata <= '0;
        else if (word_mode) host_rdata <= rx_head;
        else                host_rdata <= {8'h00, rx_head[7:0]};
      end
    end
  end
endmodule

// File: rtl/pbp_dma_ctrl.sv
module pbp_dma_ctrl
  import pbp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dma_start,
  input  logic dma_burst,
  input  logic dma_dir,
  input  logic dma_ack,
  input  logic dma_eop,
  input  logic tx_room,
  input  logic rx_avail,
  output logic dma_req
);
  dma_state_e state_q;
  logic gap_q;
  logic ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DMA_IDLE;
      gap_q   <= 1'b0;
    end else begin
      if (dma_ack && dma_eop) state_q <= DMA_IDLE;
      else if (dma_start)     state_q <= DMA_RUN;
      gap_q <= dma_ack && !dma_burst;
    end
  end

  assign ready   = dma_dir ? tx_room : rx_avail;
  assign dma_req = (state_q == DMA_RUN) && ready && !gap_q;
endmodule

// File: rtl/pbp_host_port.sv
module pbp_host_port #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        word_mode,
  input  logic [1:0]  win_bank,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic        host_byte,
  input  logic [3:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        dma_start,
  input  logic        dma_burst,
  input  logic        dma_dir,
  input  logic        dma_ack,
  input  logic        dma_eop,
  output logic        dma_req,
  output logic        tx_m_valid,
  input  logic        tx_m_ready,
  output logic [7:0]  tx_m_data,
  input  logic        rx_s_valid,
  output logic        rx_s_ready,
  input  logic [7:0]  rx_s_data,
  output logic        err_width,
  output logic        err_overrun,
  output logic        err_underrun
);
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [1:0]    tx_push_n, rx_pop_n, tx_pop_n, rx_push_n;
  logic [1:0]    need;
  logic [15:0]   rx_head;
  logic          tx_room, rx_avail;

  assign need     = word_mode ? 2'd2 : 2'd1;
  assign tx_room  = (CW'(DEPTH) - tx_cnt) >= CW'(need);
  assign rx_avail = rx_cnt >= CW'(need);

  assign tx_m_valid = tx_cnt != '0;
  assign tx_pop_n   = {1'b0, tx_m_valid && tx_m_ready};
  assign rx_s_ready = rx_cnt != CW'(DEPTH);
  assign rx_push_n  = {1'b0, rx_s_valid && rx_s_ready};

  pbp_byte_fifo #(.DEPTH(DEPTH), .IN_BYTES(2), .OUT_BYTES(1)) u_tx_buf (
    .clk(clk), .rst(rst), .push_n(tx_push_n), .wdata(host_wdata),
    .pop_n(tx_pop_n), .head(tx_m_data), .count(tx_cnt)
  );

  pbp_byte_fifo #(.DEPTH(DEPTH), .IN_BYTES(1), .OUT_BYTES(2)) u_rx_buf (
    .clk(clk), .rst(rst), .push_n(rx_push_n), .wdata(rx_s_data),
    .pop_n(rx_pop_n), .head(rx_head), .count(rx_cnt)
  );

  pbp_access_dec u_dec (
    .clk(clk), .rst(rst), .word_mode(word_mode), .win_bank(win_bank),
    .host_sel(host_sel), .host_wr(host_wr), .host_byte(host_byte),
    .host_addr(host_addr), .dma_ack(dma_ack), .tx_room(tx_room),
    .rx_avail(rx_avail), .rx_head(rx_head), .tx_push_n(tx_push_n),
    .rx_pop_n(rx_pop_n), .host_rdata(host_rdata), .err_width(err_width),
    .err_overrun(err_overrun), .err_underrun(err_underrun)
  );

  pbp_dma_ctrl u_dma (
    .clk(clk), .rst(rst), .dma_start(dma_start), .dma_burst(dma_burst),
    .dma_dir(dma_dir), .dma_ack(dma_ack), .dma_eop(dma_eop),
    .tx_room(tx_room), .rx_avail(rx_avail), .dma_req(dma_req)
  );
endmodule

// File: rtl/pbp_host_port_chk.sv
module pbp_host_port_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          word_mode,
  input logic [1:0]    win_bank,
  input logic          host_sel,
  input logic          host_wr,
  input logic          host_byte,
  input logic [3:0]    host_addr,
  input logic [15:0]   host_rdata,
  input logic          dma_burst,
  input logic          dma_ack,
  input logic          dma_eop,
  input logic          dma_req,
  input logic          tx_m_valid,
  input logic          tx_m_ready,
  input logic [7:0]    tx_m_data,
  input logic          rx_s_ready,
  input logic          err_width,
  input logic          err_overrun,
  input logic          err_underrun,
  input logic [CW-1:0] rx_cnt
);
  logic sel_port;
  assign sel_port = host_sel && (dma_ack || (win_bank == 2'b10 && host_addr == 4'h8));

  assert_width_flag_R4: assert property (@(posedge clk) disable iff (rst)
    sel_port && word_mode && host_byte |=> err_width);

  assert_sticky_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    err_overrun |=> err_overrun);

  assert_underrun_zero_R6: assert property (@(posedge clk) disable iff (rst)
    sel_port && !host_wr && !word_mode && rx_cnt == '0 |=> host_rdata == 16'h0 && err_underrun);

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    tx_m_valid && !tx_m_ready |=> tx_m_valid && $stable(tx_m_data));

  assert_rx_full_R7: assert property (@(posedge clk) disable iff (rst)
    rx_cnt == CW'(DEPTH) |-> !rx_s_ready);

  assert_single_drop_R9: assert property (@(posedge clk) disable iff (rst)
    !dma_burst && dma_ack |=> !dma_req);

  assert_eop_stop_R11: assert property (@(posedge clk) disable iff (rst)
    dma_ack && dma_eop |=> !dma_req);

  assert_sticky_width_R5: assert property (@(posedge clk) disable iff (rst)
    err_width && err_underrun |=> err_width && err_underrun);
endmodule

bind pbp_host_port pbp_host_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .word_mode(word_mode), .win_bank(win_bank),
  .host_sel(host_sel), .host_wr(host_wr), .host_byte(host_byte),
  .host_addr(host_addr), .host_rdata(host_rdata), .dma_burst(dma_burst),
  .dma_ack(dma_ack), .dma_eop(dma_eop), .dma_req(dma_req),
  .tx_m_valid(tx_m_valid), .tx_m_ready(tx_m_ready), .tx_m_data(tx_m_data),
  .rx_s_ready(rx_s_ready), .err_width(err_width), .err_overrun(err_overrun),
  .err_underrun(err_underrun), .rx_cnt(rx_cnt)
);

// File: tb/test_pbp_host_port.sv
`timescale 1ns/100ps
module test_pbp_host_port;
  localparam int DEPTH = 16;
  logic clk = 0, rst = 1;
  logic word_mode = 0, host_sel = 0, host_wr = 0, host_byte = 0;
  logic [1:0] win_bank = 2'b10;
  logic [3:0] host_addr = 4'h8;
  logic [15:0] host_wdata = '0, host_rdata;
  logic dma_start = 0, dma_burst = 0, dma_dir = 0, dma_ack = 0, dma_eop = 0, dma_req;
  logic tx_m_valid, tx_m_ready = 0, rx_s_valid = 0, rx_s_ready;
  logic [7:0] tx_m_data, rx_s_data = '0;
  logic err_width, err_overrun, err_underrun;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] tx_q[$], rx_q[$];

  always #2.5 clk = ~clk;

  pbp_host_port #(.DEPTH(DEPTH)) i_pbp_host_port (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // tx monitor: compare each accepted stream byte with the scoreboard
  always @(negedge clk) begin
    if (tx_m_valid && tx_m_ready) begin
      if (tx_q.size() == 0) chk(0, "R8 tx extra byte", tx_m_data, 0);
      else begin
        logic [7:0] e;
        e = tx_q.pop_front();
        chk(tx_m_data == e, "R3/R8 tx order", tx_m_data, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic host_wr_acc(input logic [3:0] a, input logic [15:0] d, input logic b, input bit expect_ok);
    step();
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d; host_byte = b;
    if (expect_ok) begin
      tx_q.push_back(d[7:0]);
      if (word_mode) tx_q.push_back(d[15:8]);
    end
    step();
    host_sel = 0; host_byte = 0;
  endtask

  task automatic host_rd_acc(input logic [3:0] a, output logic [15:0] d);
    step();
    host_sel = 1; host_wr = 0; host_addr = a;
    step();
    host_sel = 0;
    d = host_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    step();
    rx_s_valid = 1; rx_s_data = b; rx_q.push_back(b);
    step();
    rx_s_valid = 0;
  endtask

  task automatic rd_check(input string req);
    logic [15:0] d, e;
    host_rd_acc(4'h8, d);
    e = {8'h00, rx_q.pop_front()};
    if (word_mode) e[15:8] = rx_q.pop_front();
    chk(d == e, req, d, e);
  endtask

  task automatic drain();
    step();
    tx_m_ready = 1;
    while (tx_m_valid) @(negedge clk);
    step();
    tx_m_ready = 0;
    chk(tx_q.size() == 0, "R8 tx bytes missing", tx_q.size(), 0);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) step();
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk(dma_req == 0 && tx_m_valid == 0 && rx_s_ready == 1, "R13 reset outputs", {dma_req, tx_m_valid, rx_s_ready}, 3'b001);
    chk({err_width, err_overrun, err_underrun} == 0 && host_rdata == 0, "R13 reset flags", host_rdata, 0);

    // R2/R1 byte mode writes, ignored accesses
    host_wr_acc(4'h8, 16'hFF11, 0, 1);
    host_wr_acc(4'h9, 16'h0022, 0, 1);
    win_bank = 2'b00;
    host_wr_acc(4'h8, 16'h0099, 0, 0);
    win_bank = 2'b10;
    host_wr_acc(4'h5, 16'h0098, 0, 0);
    host_wr_acc(4'h8, 16'h0033, 0, 1);
    @(negedge clk);
    begin
      logic [7:0] h;
      h = tx_m_data;
      repeat (2) @(negedge clk);
      chk(tx_m_valid && tx_m_data == h, "R7 stalled tx holds", tx_m_data, h);
    end
    drain();

    // R3 word mode, R4 width error
    word_mode = 1;
    host_wr_acc(4'h8, 16'hB2A1, 0, 1);
    host_wr_acc(4'h8, 16'h7777, 1, 0);
    host_wr_acc(4'h9, 16'h6666, 0, 0);
    host_wr_acc(4'h8, 16'hD4C3, 0, 1);
    @(negedge clk);
    chk(err_width == 1, "R4 width flag", err_width, 1);
    drain();

    // R5 overrun
    for (int i = 0; i < DEPTH / 2; i++) host_wr_acc(4'h8, 16'(i * 16'h0202 + 16'h0100), 0, 1);
    @(negedge clk);
    chk(err_overrun == 0, "R5 no overrun when exactly full", err_overrun, 0);
    host_wr_acc(4'h8, 16'hEEEE, 0, 0);
    @(negedge clk);
    chk(err_overrun == 1, "R5 overrun flag", err_overrun, 1);
    drain();
    chk(err_overrun == 1, "R5 flag sticky", err_overrun, 1);

    // R2 byte reads, R6 underrun
    word_mode = 0;
    rx_push(8'h51); rx_push(8'h52);
    rd_check("R2 byte read 1");
    rd_check("R2 byte read 2");
    host_rd_acc(4'h8, d);
    chk(d == 0 && err_underrun == 1, "R6 byte underrun", d, 0);

    // R6 word read must not consume a lone byte
    word_mode = 1;
    rx_push(8'h61);
    host_rd_acc(4'h8, d);
    chk(d == 0, "R6 word underrun returns zero", d, 0);
    rx_push(8'h62);
    rd_check("R6 nothing consumed by failed read");

    // R8 interleaving
    rx_push(8'h71); rx_push(8'h72); rx_push(8'h73); rx_push(8'h74);
    host_wr_acc(4'h8, 16'h1211, 0, 1);
    rd_check("R8 interleaved read 1");
    host_wr_acc(4'h8, 16'h1413, 0, 1);
    rd_check("R8 interleaved read 2");
    drain();

    // R7 rx full back-pressure
    for (int i = 0; i < DEPTH; i++) rx_push(8'(8'h80 + i));
    @(negedge clk);
    chk(rx_s_ready == 0, "R7 rx full ready low", rx_s_ready, 0);
    for (int i = 0; i < DEPTH / 2; i++) rd_check("R7 rx full readback");

    // R9/R12 single-cycle receive DMA, port selected by ack (R1)
    word_mode = 0; dma_dir = 0; dma_burst = 0;
    rx_push(8'h91); rx_push(8'h92);
    step(); dma_start = 1; step(); dma_start = 0;
    @(negedge clk);
    chk(dma_req == 1, "R12 rx dma request", dma_req, 1);
    win_bank = 2'b00;
    for (int k = 0; k < 2; k++) begin
      logic [7:0] e;
      step(); dma_ack = 1; host_sel = 1; host_wr = 0; host_addr = 4'h0;
      step(); dma_ack = 0; host_sel = 0;
      e = rx_q.pop_front();
      chk(host_rdata == {8'h0, e}, "R1 ack selects port", host_rdata, e);
      @(negedge clk);
      chk(dma_req == 0, "R9 single drop", dma_req, 0);
      @(negedge clk);
      chk(dma_req == (k == 0), "R9/R12 request follows rx data", dma_req, k == 0);
    end

    // R10 burst transmit DMA until full
    dma_dir = 1; dma_burst = 1;
    step(); dma_start = 1; step(); dma_start = 0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk(dma_req == 1, "R10 burst request held", dma_req, 1);
      step(); dma_ack = 1; host_sel = 1; host_wr = 1; host_wdata = 16'(8'hC0 + i);
      tx_q.push_back(8'(8'hC0 + i));
    end
    step(); dma_ack = 0; host_sel = 0;
    @(negedge clk);
    chk(dma_req == 0, "R10 burst stops when full", dma_req, 0);
    drain();
    @(negedge clk);
    chk(dma_req == 1, "R10 burst resumes with room", dma_req, 1);

    // R11 end-of-process
    step(); dma_eop = 1; step(); dma_eop = 0;
    @(negedge clk);
    chk(dma_req == 1, "R11 eop without ack ignored", dma_req, 1);
    step(); dma_eop = 1; dma_ack = 1; host_sel = 1; host_wr = 1; host_wdata = 16'h00AA;
    tx_q.push_back(8'hAA);
    step(); dma_eop = 0; dma_ack = 0; host_sel = 0;
    repeat (3) @(negedge clk);
    chk(dma_req == 0, "R11 eop stops dma", dma_req, 0);
    drain();
    @(negedge clk);
    chk(dma_req == 0, "R11 stays stopped", dma_req, 0);

    // R13 reset again clears flags
    step(); rst = 1; step(); rst = 0;
    @(negedge clk);
    chk({err_width, err_overrun, err_underrun} == 0 && host_rdata == 0, "R13 reset clears", {err_width, err_overrun, err_underrun}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule